// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Table

This block routes up to 24 interrupt input lines to interrupt vectors. Software reaches it through two registers: a select register that names an internal register, and a 32-bit data window that reads or writes the selected register. Behind the window sit an identification register, a read-only version word, a mirror of the identification register, and one 64-bit routing entry per input line. Each entry is split into a low half and a high half. Each half has its own select value.

Each routing entry holds an 8-bit vector, a trigger-type bit and a mask bit. It also holds two status bits that only the hardware changes: a pending flag and an in-service flag. An edge-type line delivers once per rising edge. A level-type line delivers once and then sets its in-service flag. It does not deliver again until an end-of-interrupt message carrying its vector clears that flag. When several lines are ready in the same cycle, one delivery pulse per cycle leaves the block, lowest line index first. The pulse carries the entry's vector and the line number. A per-entry "used" flag records that software has written the entry at least once.

Top module: `irq_route_regfile`

## Requirements
- R1: A write through the window while select is 0x00 stores data bits 27:24 as the 4-bit ID. A read at select 0x00 or select 0x02 returns that ID in bits 27:24, with every other bit zero. A write at select 0x02 changes nothing.
- R2: A read at select 0x01 returns the constant word {8'h00, NPINS-1, 8'h00, VERSION}, which is 0x0017_0020 with the default parameters. A write there changes nothing.
- R3: Entry i is reached at select 0x10+2i (bits 31:0) and at select 0x11+2i (bits 63:32). A write to the high half replaces bits 63:32 completely and leaves the low half alone.
- R4: A write to a low half takes only the bits under mask 0xFFFF_AFFF from the data. Bit 12 (pending) and bit 14 (in-service) keep their hardware-owned values.
- R5: After reset, every entry reads 0x0001_0000 in its low half and 0 in its high half, which means only the mask bit 16 is set. The ID reads 0, no used flag is set, and no delivery pulse is asserted.
- R6: A read at any select other than 0x00–0x02 and 0x10–0x3F returns zero. A write to such a select changes no register.
- R7: An unmasked edge entry (bit 15 = 0) gives exactly one pulse per rising edge of its line. The pulse carries vector bits 7:0 and the line index. Holding the line high gives no further pulses. Pending (bit 12) reads 0 once the pulse has been sent.
- R8: An unmasked level entry (bit 15 = 1) whose line is high gives one pulse and sets in-service (bit 14). While bit 14 is set, no further pulse leaves for that entry.
- R9: An end-of-interrupt with vector V clears bit 14 in every level entry whose vector equals V. Entries with other vectors keep bit 14. A level line that is still high then delivers again.
- R10: While mask bit 16 is set, the entry delivers nothing. An edge that rises while the entry is masked is dropped and is not delivered after the entry is unmasked.
- R11: A write to either half of an entry sets that entry's used flag. The flag stays set until reset.
- R12: Entries that are ready in the same cycle are delivered one per cycle, lowest line index first.
- R13: If a software write to a low half and a delivery of that entry fall in the same cycle, the status bits take the values set by the delivery.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_we | input | 1 | Load the select register |
| sel_wdata | input | 8 | New select value |
| win_we | input | 1 | Write the selected register through the window |
| win_wdata | input | 32 | Window write data |
| win_rdata | output | 32 | Contents of the selected register (combinational) |
| pin_req | input | 24 | Interrupt input lines, one per entry |
| eoi_valid | input | 1 | End-of-interrupt message strobe |
| eoi_vector | input | 8 | Vector carried by the end-of-interrupt |
| irq_valid | output | 1 | One-cycle delivery pulse |
| irq_vector | output | 8 | Vector of the delivered entry |
| irq_pin | output | 5 | Line index of the delivered entry |
| entry_used | output | 24 | Per-entry written-at-least-once flags |

## Verification
A window write to an entry's low half can land in the same clock edge as the delivery of that entry. Both then update the in-service and pending bits of that entry. The bench provokes this by raising a level line and driving a low-half write to the same entry on the same falling edge, with bit 14 clear in the write data. The case passes when exactly one pulse follows and bit 14 reads back as set, so the hardware update overrides the write. A similar overlap is that several lines become ready together. The bench checks that case by comparing the order of the delivered line indices against ascending index order.

// File: rtl/irq_route_pkg.sv
// Package: shared field positions and widths for the interrupt redirection
// table. Assumes 32-bit window and 64-bit entries split into two halves.
package irq_route_pkg;
    localparam int WIN_W    = 32;
    localparam int ENT_W    = 64;
    localparam int HALF_W   = 32;
    localparam int VEC_W    = 8;
    localparam int ID_W     = 4;
    localparam int ID_LSB   = 24;

    // Bit positions inside the low half of an entry
    localparam int BIT_PEND = 12;   // hardware-owned pending flag
    localparam int BIT_INSV = 14;   // hardware-owned in-service flag
    localparam int BIT_TRIG = 15;   // 0 edge, 1 level
    localparam int BIT_MASK = 16;   // 1 blocks delivery

    // Bits of a low-half write taken from software data
    localparam logic [HALF_W-1:0] LO_SW_MASK = 32'hFFFF_AFFF;

    // Entry value after reset: masked, everything else clear
    localparam logic [ENT_W-1:0] ENT_RESET = ENT_W'(1) << BIT_MASK;
endpackage

// File: rtl/irq_route_decode.sv
// Module: decodes the select register into a register class and, for the
// table range, an entry index and half indicator. Assumes the table starts
// at an even select value and fits below 2**SEL_W.
module irq_route_decode #(
    parameter int                 SEL_W    = 8,
    parameter int                 NPINS    = 24,
    parameter int                 IDX_W    = 5,
    parameter logic [SEL_W-1:0]   ENT_BASE = 8'h10
) (
    input  logic [SEL_W-1:0] sel,
    output logic             is_id,
    output logic             is_ver,
    output logic             is_arb,
    output logic             is_ent,
    output logic [IDX_W-1:0] ent_idx,
    output logic             is_hi
);
    localparam logic [SEL_W-1:0] SEL_ID  = SEL_W'(0);
    localparam logic [SEL_W-1:0] SEL_VER = SEL_W'(1);
    localparam logic [SEL_W-1:0] SEL_ARB = SEL_W'(2);
    localparam logic [SEL_W-1:0] ENT_END = SEL_W'(int'(ENT_BASE) + 2 * NPINS);

    logic [SEL_W-1:0] off;

    // Classify the select value and split the table offset into index/half
    always_comb begin
        off     = sel - ENT_BASE;
        is_id   = (sel == SEL_ID);
        is_ver  = (sel == SEL_VER);
        is_arb  = (sel == SEL_ARB);
        is_ent  = (sel >= ENT_BASE) && (sel < ENT_END);
        ent_idx = IDX_W'(off >> 1);
        is_hi   = off[0];
    end
endmodule

// File: rtl/irq_route_prio.sv
// Module: fixed-priority picker, lowest request index wins. Assumes at most
// one delivery per cycle is wanted downstream.
module irq_route_prio #(
    parameter int N     = 24,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] grant_idx,
    output logic             any
);
    // Scan from index 0 upward and take the first request
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i]  = 1'b1;
                grant_idx = IDX_W'(i);
                any       = 1'b1;
            end
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R12
    AST_GRANT_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> ((grant & req) == grant) && (|grant)); // R12
endmodule

// File: rtl/irq_route_entry.sv
// Module: one 64-bit redirection entry with its hardware status bits, edge
// detector and used flag. Assumes at most one of wr_lo/wr_hi per cycle and
// that grant is only given while req is high.
module irq_route_entry
    import irq_route_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [WIN_W-1:0]  wdata,
    input  logic              pin,
    input  logic              grant,
    input  logic              eoi_valid,
    input  logic [VEC_W-1:0]  eoi_vector,
    output logic [ENT_W-1:0]  ent_q,
    output logic              req,
    output logic              used_q
);
    logic              pin_q;
    logic              trig, masked, pend, insv, rise, eoi_hit;
    logic              pend_nxt, insv_nxt;
    logic [VEC_W-1:0]  vec;
    logic [HALF_W-1:0] lo_nxt, hi_nxt;

    // Field extraction, readiness and next hardware status
    always_comb begin
        trig    = ent_q[BIT_TRIG];
        masked  = ent_q[BIT_MASK];
        pend    = ent_q[BIT_PEND];
        insv    = ent_q[BIT_INSV];
        vec     = ent_q[VEC_W-1:0];
        rise    = pin && !pin_q;
        eoi_hit = eoi_valid && trig && (eoi_vector == vec);
        req     = !masked && (trig ? (pin && !insv) : pend);
        if (trig) begin
            pend_nxt = pin && !insv && !masked && !grant;
        end else begin
            pend_nxt = (pend || (rise && !masked)) && !grant;
        end
        if (grant && trig) begin
            insv_nxt = 1'b1;
        end else if (eoi_hit) begin
            insv_nxt = 1'b0;
        end else begin
            insv_nxt = insv;
        end
    end

    // Merge software write data with hardware-owned status bits
    always_comb begin
        lo_nxt = wr_lo ? (wdata & LO_SW_MASK) : ent_q[HALF_W-1:0];
        lo_nxt[BIT_PEND] = pend_nxt;
        lo_nxt[BIT_INSV] = insv_nxt;
        hi_nxt = wr_hi ? wdata : ent_q[ENT_W-1:HALF_W];
    end

    // Entry storage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= ENT_RESET;
        end else begin
            ent_q <= {hi_nxt, lo_nxt};
        end
    end

    // Line history for edge detection and sticky used flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q  <= 1'b0;
            used_q <= 1'b0;
        end else begin
            pin_q  <= pin;
            used_q <= used_q || wr_lo || wr_hi;
        end
    end

    AST_DELIVERY_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !ent_q[BIT_PEND]); // R7
    AST_LEVEL_SETS_INSV: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && trig) |=> ent_q[BIT_INSV]); // R8
    AST_NO_REQ_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && insv) |-> !req); // R8
    AST_EOI_CLEARS_INSV: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_hit && !grant) |=> !ent_q[BIT_INSV]); // R9
    AST_WRITE_KEEPS_INSV: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !grant && !eoi_valid) |=> $stable(ent_q[BIT_INSV])); // R4
    AST_MASK_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        masked |-> !req); // R10
    AST_USED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        used_q |=> used_q); // R11
endmodule

// File: rtl/irq_route_regfile.sv
// Module: top of the interrupt redirection table. Holds the select register,
// the ID register and the entry array, serves the data window and emits one
// registered delivery pulse per cycle. Assumes window reads are combinational
// from the current select value.
module irq_route_regfile
    import irq_route_pkg::*;
#(
    parameter int               NPINS    = 24,
    parameter int               SEL_W    = 8,
    parameter logic [SEL_W-1:0] ENT_BASE = 8'h10,
    parameter logic [7:0]       VERSION  = 8'h20
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel_we,
    input  logic [SEL_W-1:0]         sel_wdata,
    input  logic                     win_we,
    input  logic [WIN_W-1:0]         win_wdata,
    output logic [WIN_W-1:0]         win_rdata,
    input  logic [NPINS-1:0]         pin_req,
    input  logic                     eoi_valid,
    input  logic [VEC_W-1:0]         eoi_vector,
    output logic                     irq_valid,
    output logic [VEC_W-1:0]         irq_vector,
    output logic [$clog2(NPINS)-1:0] irq_pin,
    output logic [NPINS-1:0]         entry_used
);
    localparam int IDX_W = $clog2(NPINS);
    localparam logic [WIN_W-1:0] VER_WORD = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};

    logic [SEL_W-1:0] sel_q;
    logic [ID_W-1:0]  id_q;
    logic             is_id, is_ver, is_arb, is_ent, is_hi;
    logic [IDX_W-1:0] ent_idx;
    logic [ENT_W-1:0] ent_q [NPINS];
    logic [NPINS-1:0] wr_lo, wr_hi, req, grant;
    logic [IDX_W-1:0] grant_idx;
    logic             grant_any;
    logic [VEC_W-1:0] grant_vec;

    // Select register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (sel_we) begin
            sel_q <= sel_wdata;
        end
    end

    irq_route_decode #(
        .SEL_W(SEL_W), .NPINS(NPINS), .IDX_W(IDX_W), .ENT_BASE(ENT_BASE)
    ) i_decode (
        .sel(sel_q), .is_id(is_id), .is_ver(is_ver), .is_arb(is_arb),
        .is_ent(is_ent), .ent_idx(ent_idx), .is_hi(is_hi)
    );

    // ID register, written only at the ID select
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (win_we && is_id) begin
            id_q <= win_wdata[ID_LSB +: ID_W];
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        assign wr_lo[g] = win_we && is_ent && (ent_idx == IDX_W'(g)) && !is_hi;
        assign wr_hi[g] = win_we && is_ent && (ent_idx == IDX_W'(g)) && is_hi;

        irq_route_entry i_entry (
            .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo[g]), .wr_hi(wr_hi[g]),
            .wdata(win_wdata), .pin(pin_req[g]), .grant(grant[g]),
            .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
            .ent_q(ent_q[g]), .req(req[g]), .used_q(entry_used[g])
        );
    end

    irq_route_prio #(.N(NPINS), .IDX_W(IDX_W)) i_prio (
        .clk(clk), .rst_n(rst_n), .req(req), .grant(grant),
        .grant_idx(grant_idx), .any(grant_any)
    );

    // Window read multiplexer; undefined selects read zero
    always_comb begin
        win_rdata = '0;
        if (is_id || is_arb) begin
            win_rdata[ID_LSB +: ID_W] = id_q;
        end else if (is_ver) begin
            win_rdata = VER_WORD;
        end else begin
            for (int i = 0; i < NPINS; i++) begin
                if (is_ent && (ent_idx == IDX_W'(i))) begin
                    win_rdata = is_hi ? ent_q[i][ENT_W-1:HALF_W] : ent_q[i][HALF_W-1:0];
                end
            end
        end
    end

    // Vector of the granted entry
    always_comb begin
        grant_vec = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (grant[i]) begin
                grant_vec = ent_q[i][VEC_W-1:0];
            end
        end
    end

    // Registered delivery pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
            irq_pin    <= '0;
        end else begin
            irq_valid  <= grant_any;
            irq_vector <= grant_vec;
            irq_pin    <= grant_idx;
        end
    end

    AST_UNDEF_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_id || is_ver || is_arb || is_ent) |-> (win_rdata == '0)); // R6
    AST_ID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_we && is_id) |=> $stable(id_q)); // R1
    AST_ONE_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wr_lo, wr_hi}) <= 1); // R3
endmodule

// File: tb/test_irq_route_regfile.sv
module test_irq_route_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_we = 1'b0;
    logic [7:0]  sel_wdata = '0;
    logic        win_we = 1'b0;
    logic [31:0] win_wdata = '0;
    logic [31:0] win_rdata;
    logic [23:0] pin_req = '0;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic [4:0]  irq_pin;
    logic [23:0] entry_used;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic [7:0] last_vec;
    logic [4:0] pin_log [4];
    logic [31:0] model_lo [24];
    logic [31:0] model_hi [24];
    logic [23:0] model_used;
    logic [31:0] rd;

    irq_route_regfile i_irq_route_regfile (
        .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
        .win_we(win_we), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .pin_req(pin_req), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_pin(irq_pin),
        .entry_used(entry_used)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && irq_valid) begin
            if (pulses < 4) pin_log[pulses] = irq_pin;
            pulses   = pulses + 1;
            last_vec = irq_vector;
        end
    end

    function automatic logic [7:0] sel_of(input int idx, input bit hi);
        return 8'(8'h10 + 2 * idx + (hi ? 1 : 0));
    endfunction
    function automatic logic [31:0] exp_lo(input logic [31:0] d);
        return d & 32'hFFFF_AFFF;
    endfunction
    function automatic logic [31:0] exp_id(input logic [31:0] d);
        return {4'h0, d[27:24], 24'h0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic set_sel(input logic [7:0] s);
        @(negedge clk); sel_we = 1'b1; sel_wdata = s;
        @(negedge clk); sel_we = 1'b0;
    endtask
    task automatic wr_win(input logic [31:0] d);
        @(negedge clk); win_we = 1'b1; win_wdata = d;
        @(negedge clk); win_we = 1'b0;
    endtask
    task automatic wr_reg(input logic [7:0] s, input logic [31:0] d);
        set_sel(s); wr_win(d);
    endtask
    task automatic rd_reg(input logic [7:0] s, output logic [31:0] d);
        set_sel(s); #1 d = win_rdata;
    endtask
    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk); eoi_valid = 1'b0;
    endtask
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset state
        check("R5 used after reset", 32'(entry_used), 32'h0);
        check("R5 no pulse after reset", 32'(irq_valid), 32'h0);
        rd_reg(sel_of(0, 0), rd);  check("R5 entry0 lo", rd, 32'h0001_0000);
        rd_reg(sel_of(23, 1), rd); check("R5 entry23 hi", rd, 32'h0);
        rd_reg(8'h00, rd);         check("R5 id", rd, 32'h0);

        // R1 / R2 identification registers
        wr_reg(8'h00, 32'hA5F3_1234);
        rd_reg(8'h00, rd); check("R1 id read", rd, exp_id(32'hA5F3_1234));
        rd_reg(8'h02, rd); check("R1 arb read", rd, exp_id(32'hA5F3_1234));
        wr_reg(8'h02, 32'h0C00_0000);
        rd_reg(8'h00, rd); check("R1 arb write ignored", rd, exp_id(32'hA5F3_1234));
        rd_reg(8'h01, rd); check("R2 version", rd, 32'h0017_0020);
        wr_reg(8'h01, 32'hFFFF_FFFF);
        rd_reg(8'h01, rd); check("R2 version write ignored", rd, 32'h0017_0020);

        // R3 R4 R11 constrained random table writes, lines idle
        for (int i = 0; i < 24; i++) begin
            model_lo[i] = 32'h0001_0000;
            model_hi[i] = 32'h0;
        end
        model_used = '0;
        for (int k = 0; k < 60; k++) begin
            int idx;
            bit hi;
            logic [31:0] d;
            idx = int'($urandom % 24);
            hi  = 1'($urandom % 2);
            d   = $urandom;
            wr_reg(sel_of(idx, hi), d);
            if (hi) model_hi[idx] = d; else model_lo[idx] = exp_lo(d);
            model_used[idx] = 1'b1;
        end
        for (int i = 0; i < 24; i++) begin
            rd_reg(sel_of(i, 0), rd); check("R4 random lo readback", rd, model_lo[i]);
            rd_reg(sel_of(i, 1), rd); check("R3 random hi readback", rd, model_hi[i]);
        end
        check("R11 used flags", 32'(entry_used), 32'(model_used));

        // R6 undefined selects
        wr_reg(8'h05, 32'hFFFF_FFFF);
        wr_reg(8'h40, 32'hFFFF_FFFF);
        rd_reg(8'h05, rd); check("R6 read 0x05", rd, 32'h0);
        rd_reg(8'h40, rd); check("R6 read 0x40", rd, 32'h0);
        rd_reg(8'hFF, rd); check("R6 read 0xFF", rd, 32'h0);
        rd_reg(8'h00, rd); check("R6 id untouched", rd, exp_id(32'hA5F3_1234));
        rd_reg(sel_of(23, 1), rd); check("R6 entry23 untouched", rd, model_hi[23]);

        // R7 edge delivery
        wr_reg(sel_of(3, 0), 32'h0000_0041);
        idle(2); pulses = 0;
        @(negedge clk); pin_req[3] = 1'b1;
        @(negedge clk); pin_req[3] = 1'b0;
        idle(8);
        check("R7 edge one pulse", 32'(pulses), 32'd1);
        check("R7 edge vector", 32'(last_vec), 32'h41);
        check("R7 edge pin", 32'(pin_log[0]), 32'd3);
        @(negedge clk); pin_req[3] = 1'b1;
        idle(12);
        check("R7 held line single pulse", 32'(pulses), 32'd2);
        rd_reg(sel_of(3, 0), rd); check("R7 pending cleared", rd, 32'h0000_0041);
        pin_req[3] = 1'b0;

        // R10 masked edge is dropped
        wr_reg(sel_of(3, 0), 32'h0001_0041);
        pulses = 0;
        @(negedge clk); pin_req[3] = 1'b1;
        idle(4);
        wr_reg(sel_of(3, 0), 32'h0000_0041);
        idle(8);
        check("R10 masked edge dropped", 32'(pulses), 32'd0);
        pin_req[3] = 1'b0;

        // R8 R9 R4 level delivery, in-service gating and EOI
        wr_reg(sel_of(5, 0), 32'h0000_8052);
        pulses = 0;
        @(negedge clk); pin_req[5] = 1'b1;
        idle(15);
        check("R8 level one pulse", 32'(pulses), 32'd1);
        check("R8 level vector", 32'(last_vec), 32'h52);
        rd_reg(sel_of(5, 0), rd); check("R8 in-service set", rd, 32'h0000_C052);
        wr_win(32'h0000_9052);
        #1 check("R4 status bits kept", win_rdata, 32'h0000_C052);
        send_eoi(8'h53); idle(6);
        check("R9 other vector no pulse", 32'(pulses), 32'd1);
        #1 check("R9 other vector keeps flag", win_rdata, 32'h0000_C052);
        send_eoi(8'h52); idle(6);
        check("R9 redelivery after eoi", 32'(pulses), 32'd2);
        pin_req[5] = 1'b0;
        send_eoi(8'h52); idle(2);
        #1 check("R9 flag cleared", win_rdata, 32'h0000_8052);

        // R10 masked level, then unmask
        wr_reg(sel_of(7, 0), 32'h0001_8077);
        pulses = 0;
        @(negedge clk); pin_req[7] = 1'b1;
        idle(10);
        check("R10 masked level silent", 32'(pulses), 32'd0);
        #1 check("R10 masked status clear", win_rdata, 32'h0001_8077);
        wr_win(32'h0000_8077); idle(6);
        check("R10 unmask delivers", 32'(pulses), 32'd1);
        pin_req[7] = 1'b0;
        send_eoi(8'h77);

        // R12 priority and R9 broadcast EOI
        wr_reg(sel_of(8, 0), 32'h0000_8060);
        wr_reg(sel_of(9, 0), 32'h0000_8060);
        idle(2); pulses = 0;
        @(negedge clk); pin_req[9] = 1'b1; pin_req[8] = 1'b1;
        idle(8);
        check("R12 two pulses", 32'(pulses), 32'd2);
        check("R12 first lowest", 32'(pin_log[0]), 32'd8);
        check("R12 second", 32'(pin_log[1]), 32'd9);
        pin_req[9] = 1'b0; pin_req[8] = 1'b0;
        send_eoi(8'h60); idle(2);
        rd_reg(sel_of(8, 0), rd); check("R9 broadcast entry8", rd, 32'h0000_8060);
        rd_reg(sel_of(9, 0), rd); check("R9 broadcast entry9", rd, 32'h0000_8060);

        // R13 write and delivery in the same cycle
        wr_reg(sel_of(10, 0), 32'h0000_8070);
        idle(2); pulses = 0;
        @(negedge clk); pin_req[10] = 1'b1; win_we = 1'b1; win_wdata = 32'h0000_8070;
        @(negedge clk); win_we = 1'b0;
        idle(6);
        check("R13 one pulse", 32'(pulses), 32'd1);
        #1 check("R13 in-service wins", win_rdata, 32'h0000_C070);
        pin_req[10] = 1'b0;

        finish_run();
    end
endmodule